// File: doc/BRIEF.md
# SMII Transmit Serializer

This block sits on the MAC side of a serial media-independent link and turns a byte-wide transmit interface into the single-bit transmit line plus the sync pulse. Everything runs from one continuous 125 MHz reference clock. A free-running ten-cycle frame counter produces the sync pulse and also sets the moment at which each ten-bit segment is loaded into the output shift register.

A segment carries the error flag, the enable flag and one data byte. At 100 Mbps every segment carries a fresh byte. At 10 Mbps the same segment is sent in ten consecutive frames before the next byte is taken. A one-cycle byte request tells the MAC when its byte, enable and error inputs are sampled. The speed select is read only at those same instants, so a byte is never split across two rates.

Top module: `smii_tx_ser`

## Requirements
- R1: While `rst_n` is low, `smii_sync_o`, `smii_tx_o` and `byte_req_o` are all 0. Reset puts the block in 100 Mbps mode.
- R2: After reset is released, `smii_sync_o` stays low for the first 9 clock cycles. It goes high for exactly one cycle in cycle 10, and then once every 10 cycles.
- R3: A segment occupies the 10 cycles that start with the cycle in which `smii_sync_o` is high. Bit 0 is the error flag and bit 1 is the enable flag. Bits 2 to 9 carry `txd_i[0]` to `txd_i[7]`. Bit k appears on `smii_tx_o` k cycles after the sync cycle.
- R4: In 100 Mbps mode, `byte_req_o` is high in the last cycle of every segment, and every segment carries a newly captured byte.
- R5: In 10 Mbps mode, each captured byte is sent in 10 consecutive identical segments. `byte_req_o` is high only in the last cycle of the tenth segment.
- R6: `tx_en_i`, `tx_er_i` and `txd_i` are sampled only at the clock edge that ends a cycle in which `byte_req_o` is high. Changes at any other time have no effect on the stream.
- R7: A byte captured with `tx_en_i` low is sent as an all-zero segment, whatever `tx_er_i` and `txd_i` hold.
- R8: `speed_100_i` (1 = 100 Mbps, 0 = 10 Mbps) is sampled only at the edge that ends a `byte_req_o` cycle. It governs every segment from that byte onward. Changes at other times are ignored. The first segment boundary after reset is always a byte boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_100_i | input | 1 | Rate select: 1 = 100 Mbps, 0 = 10 Mbps |
| tx_en_i | input | 1 | MAC transmit enable for the requested byte |
| tx_er_i | input | 1 | MAC transmit error for the requested byte |
| txd_i | input | 8 | MAC transmit byte |
| byte_req_o | output | 1 | High in the cycle whose closing edge samples the byte inputs |
| smii_sync_o | output | 1 | Segment sync pulse, one cycle in ten |
| smii_tx_o | output | 1 | Serial transmit data and control |

## Verification
The bench builds the block with its defaults: an 8-bit byte, which gives 10-cycle segments, and a repeat factor of 10. With these values the full 10 Mbps window can be walked frame by frame. In that window the bench moves the data inputs and the speed select in the middle of a repetition and sees no effect until the tenth segment. The defaults also bring both rate transitions within reach: from 100 to 10 Mbps at a byte boundary, and back again after a complete repetition.

// File: rtl/smii_tx_pkg.sv
package smii_tx_pkg;

  typedef enum logic {
    SPD_10M  = 1'b0,
    SPD_100M = 1'b1
  } smii_speed_e;

  // True when a counter value is the last of a span of the given length
  function automatic logic at_last(input int unsigned value, input int unsigned span);
    return value == span - 1;
  endfunction

endpackage

// File: rtl/smii_frame_ctr.sv
module smii_frame_ctr #(
  parameter int unsigned CYC = 10,
  localparam int unsigned CW = $clog2(CYC)
) (
  input  logic clk,
  input  logic rst_n,
  output logic seg_end_o,
  output logic sync_o
);
  import smii_tx_pkg::*;

  logic [CW-1:0] cnt_q;

  assign seg_end_o = at_last(int'(cnt_q), CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sync_o <= 1'b0;
    end else begin
      cnt_q  <= seg_end_o ? '0 : cnt_q + 1'b1;
      sync_o <= seg_end_o;
    end
  end
endmodule

// File: rtl/smii_rep_ctr.sv
module smii_rep_ctr #(
  parameter int unsigned REP = 10,
  localparam int unsigned RW = $clog2(REP)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      seg_end_i,
  input  logic                      speed_100_i,
  output logic                      byte_bnd_o,
  output smii_tx_pkg::smii_speed_e  mode_o,
  output logic [RW-1:0]             rep_o
);
  import smii_tx_pkg::*;

  logic rep_done;

  assign rep_done   = at_last(int'(rep_o), REP);
  assign byte_bnd_o = seg_end_i && (mode_o == SPD_100M || rep_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_o  <= '0;
      mode_o <= SPD_100M;
    end else if (byte_bnd_o) begin
      rep_o  <= '0;
      mode_o <= speed_100_i ? SPD_100M : SPD_10M;
    end else if (seg_end_i) begin
      rep_o  <= rep_o + 1'b1;
    end
  end
endmodule

// File: rtl/smii_seg_shift.sv
module smii_seg_shift #(
  parameter int unsigned DW = 8,
  localparam int unsigned SW = DW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seg_end_i,
  input  logic          byte_bnd_i,
  input  logic          tx_en_i,
  input  logic          tx_er_i,
  input  logic [DW-1:0] txd_i,
  output logic          tx_o
);
  logic [SW-1:0] fresh;
  logic [SW-1:0] hold_q;
  logic [SW-1:0] shreg_q;
  logic [SW-1:0] next_seg;

  assign fresh[0] = tx_er_i & tx_en_i;
  assign fresh[1] = tx_en_i;

  for (genvar i = 0; i < DW; i++) begin : g_data
    assign fresh[2+i] = txd_i[i] & tx_en_i;
  end

  assign next_seg = byte_bnd_i ? fresh : hold_q;
  assign tx_o     = shreg_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      shreg_q <= '0;
    end else begin
      if (byte_bnd_i) hold_q <= fresh;
      if (seg_end_i) shreg_q <= next_seg;
      else           shreg_q <= shreg_q >> 1;
    end
  end
endmodule

// File: rtl/smii_tx_ser.sv
module smii_tx_ser #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned REP_SLOW = 10,
  localparam int unsigned SEG_CYC = DATA_W + 2,
  localparam int unsigned RW      = $clog2(REP_SLOW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              speed_100_i,
  input  logic              tx_en_i,
  input  logic              tx_er_i,
  input  logic [DATA_W-1:0] txd_i,
  output logic              byte_req_o,
  output logic              smii_sync_o,
  output logic              smii_tx_o
);
  import smii_tx_pkg::*;

  // Named internal events, observed by the bound checker
  logic          seg_end;
  logic          byte_bnd;
  smii_speed_e   mode;
  logic [RW-1:0] rep;

  smii_frame_ctr #(.CYC(SEG_CYC)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .seg_end_o (seg_end),
    .sync_o    (smii_sync_o)
  );

  smii_rep_ctr #(.REP(REP_SLOW)) u_rep (
    .clk         (clk),
    .rst_n       (rst_n),
    .seg_end_i   (seg_end),
    .speed_100_i (speed_100_i),
    .byte_bnd_o  (byte_bnd),
    .mode_o      (mode),
    .rep_o       (rep)
  );

  smii_seg_shift #(.DW(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .seg_end_i  (seg_end),
    .byte_bnd_i (byte_bnd),
    .tx_en_i    (tx_en_i),
    .tx_er_i    (tx_er_i),
    .txd_i      (txd_i),
    .tx_o       (smii_tx_o)
  );

  assign byte_req_o = byte_bnd;
endmodule

// File: rtl/smii_tx_ser_chk.sv
module smii_tx_ser_chk #(
  parameter int unsigned REP = 10,
  localparam int unsigned RW = $clog2(REP)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     sync,
  input logic                     tx,
  input logic                     req,
  input logic                     tx_en,
  input logic                     seg_end,
  input logic                     byte_bnd,
  input smii_tx_pkg::smii_speed_e mode,
  input logic [RW-1:0]            rep
);
  import smii_tx_pkg::*;

  // Segments seen since the last byte boundary (checker's own count)
  int unsigned seg_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seg_seen <= 0;
    else if (byte_bnd) seg_seen <= 0;
    else if (seg_end)  seg_seen <= seg_seen + 1;
  end

  always_comb begin
    if (!rst_n) begin
      a_reset_quiet_r1: assert (!sync && !tx && !req);
    end
  end

  p_sync_follows_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seg_end |=> sync);
  p_sync_only_after_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> $past(seg_end));
  p_req_at_seg_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> seg_end);
  p_fast_every_seg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_end && mode == SPD_100M) |-> req);
  p_slow_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_bnd && mode == SPD_10M) |-> seg_seen == REP - 1);
  p_rep_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rep) < REP);
  p_idle_bit0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !tx_en) |=> !tx);
  p_mode_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_bnd |=> $stable(mode));
endmodule

bind smii_tx_ser smii_tx_ser_chk #(.REP(REP_SLOW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sync     (smii_sync_o),
  .tx       (smii_tx_o),
  .req      (byte_req_o),
  .tx_en    (tx_en_i),
  .seg_end  (seg_end),
  .byte_bnd (byte_bnd),
  .mode     (mode),
  .rep      (rep)
);

// File: tb/sim_smii_tx_ser.sv
`timescale 1ns/1ps
module sim_smii_tx_ser;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       speed_100;
  logic       tx_en;
  logic       tx_er;
  logic [7:0] txd;
  logic       byte_req;
  logic       sync;
  logic       tx;

  int unsigned n_chk  = 0;
  int unsigned n_fail = 0;
  bit          done   = 1'b0;

  always #2 clk = ~clk;

  smii_tx_ser u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .speed_100_i (speed_100),
    .tx_en_i     (tx_en),
    .tx_er_i     (tx_er),
    .txd_i       (txd),
    .byte_req_o  (byte_req),
    .smii_sync_o (sync),
    .smii_tx_o   (tx)
  );

  // Expected segment: LSB first is error flag, enable flag, then data bits 0..7
  function automatic logic [9:0] want_seg(input logic en, input logic er, input logic [7:0] d);
    return en ? {d, 1'b1, er} : 10'd0;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic drive(input logic en, input logic er, input logic [7:0] d);
    tx_en = en;
    tx_er = er;
    txd   = d;
  endtask

  // Called at the negedge of a sync cycle; returns at the negedge of the last bit
  task automatic grab(output logic [9:0] s);
    check("R2 sync high at segment start", 32'(sync), 32'd1);
    s[0] = tx;
    for (int k = 1; k < 10; k++) begin
      @(negedge clk);
      if (sync !== 1'b0) check("R2 sync low inside segment", 32'(sync), 32'd0);
      s[k] = tx;
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    speed_100 = 1'b1;
    drive(1'b0, 1'b0, 8'h00);
    repeat (3) @(negedge clk);
    check("R1 sync in reset", 32'(sync), 32'd0);
    check("R1 tx in reset", 32'(tx), 32'd0);
    check("R1 req in reset", 32'(byte_req), 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_startup;
    logic early = 1'b0;
    for (int i = 1; i <= 9; i++) begin
      @(negedge clk);
      if (sync) early = 1'b1;
      if (i < 9 && byte_req) early = 1'b1;
    end
    check("R2 no sync in first 9 cycles", 32'(early), 32'd0);
    check("R8 first boundary is a byte boundary", 32'(byte_req), 32'd1);
  endtask

  // Starts at a request negedge; sends one byte at 100 Mbps
  task automatic t_fast_byte(input logic er, input logic [7:0] d);
    logic [9:0] s;
    drive(1'b1, er, d);
    @(negedge clk);
    drive(1'b1, ~er, ~d);                 // R6: post-capture change ignored
    grab(s);
    check("R3 R4 R6 fast segment content", 32'(s), 32'(want_seg(1'b1, er, d)));
    check("R4 request every segment", 32'(byte_req), 32'd1);
  endtask

  task automatic t_idle;
    logic [9:0] s;
    drive(1'b0, 1'b1, 8'hFF);
    @(negedge clk);
    grab(s);
    check("R7 idle segment all zero", 32'(s), 32'd0);
    check("R4 request after idle segment", 32'(byte_req), 32'd1);
  endtask

  task automatic t_slow;
    logic [9:0] s;
    drive(1'b1, 1'b0, 8'h5A);
    speed_100 = 1'b0;                     // R8: taken at this boundary
    for (int r = 0; r < 10; r++) begin
      @(negedge clk);
      if (r == 0) drive(1'b1, 1'b1, 8'hC3);   // R6: mid-repeat change ignored
      if (r == 3) speed_100 = 1'b1;           // R8: mid-repeat speed change ignored
      grab(s);
      check("R5 repeated slow segment", 32'(s), 32'(want_seg(1'b1, 1'b0, 8'h5A)));
      check("R5 R8 request only on tenth segment", 32'(byte_req), 32'(r == 9));
    end
    @(negedge clk);
    grab(s);
    check("R5 R6 next byte after ten repeats", 32'(s), 32'(want_seg(1'b1, 1'b1, 8'hC3)));
    check("R8 back to 100 Mbps after byte boundary", 32'(byte_req), 32'd1);
    drive(1'b1, 1'b0, 8'h81);
    @(negedge clk);
    grab(s);
    check("R4 fast byte after slow window", 32'(s), 32'(want_seg(1'b1, 1'b0, 8'h81)));
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    t_reset();
    t_startup();
    t_fast_byte(1'b0, 8'hA5);
    t_fast_byte(1'b1, 8'h3C);
    t_fast_byte(1'b0, 8'h00);
    t_fast_byte(1'b0, 8'hFF);
    t_idle();
    t_fast_byte(1'b0, 8'h96);
    t_slow();
    done = 1'b1;
    report();
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end
endmodule